// File: doc/BRIEF.md
# Parallel EEPROM Host Write/Read Sequencer

This block is a host-side master for a byte-wide parallel EEPROM. It drives the memory's active-low chip enable, output enable and write enable, an 11-bit address and a split bidirectional data bus: a value out, a drive enable and a value in. A command carries a read/write flag, an address and a data byte. It is taken over a valid/ready handshake, and only one command is in flight at a time.

A read holds the address and asserts chip enable and output enable for a programmable access window. It samples the bus at the end of that window and returns the byte. A write forms a strobe with a setup phase, a write-enable pulse and a hold phase, each lasting a programmable number of clock cycles. The memory then programs the byte on its own. While it does, a read of that address returns the written bit 7 inverted. The sequencer therefore reads the same address repeatedly, with a gap between reads, until bit 7 matches the written value. If that has not happened within a cycle budget, it reports a timeout instead.

Each command ends with a one-cycle response pulse. The pulse carries the last byte sampled and a timeout flag.

Top module: `eep_host_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, all three strobes are high, `dq_oe` is 0 and `rsp_valid` is 0.
- R2: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is then 0 from the next cycle up to and including the single cycle in which `rsp_valid` is 1. `cmd_ready` is 1 again in the cycle after that.
- R3: `cmd_valid` asserted while `cmd_ready` is 0 has no effect: no strobe and no change to memory contents.
- R4: A write strobe proceeds in three phases, with chip enable low and output enable high throughout:
  - `T_SETUP` cycles with the address and data driven and write enable high;
  - exactly `T_WPULSE` cycles with write enable low;
  - `T_HOLD` cycles with write enable high and the data still driven.
- R5: The address does not change while chip enable is low.
- R6: A read keeps write enable high, holds chip enable and output enable low for exactly `T_RDACC` cycles, and samples the bus on the last of them. It returns that byte on `rsp_data` with `rsp_timeout` = 0.
- R7: `dq_oe` is 0 on every cycle in which output enable is low.
- R8: After a write, the block reads the same address repeatedly. Before every fall of output enable, output enable has been high for at least `T_GAP` cycles. The write completes on the first read whose bit 7 (the data MSB) equals the written bit 7. It reports `rsp_timeout` = 0, and `rsp_data` holds that byte.
- R9: The watchdog counts from the cycle after the write pulse ends. A poll that ends once `TIMEOUT_CYC` cycles have elapsed, and that still sees a mismatch, ends the command with `rsp_timeout` = 1. No further strobes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Last byte sampled from the memory |
| rsp_timeout | output | 1 | Write polling gave up |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address to memory |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Host drives the data bus |
| mem_dq_in | input | DATA_W | Data read from the bus |

## Verification
A wrong state or phase count shows up within one strobe period. It appears as a write pulse of the wrong length, output enable overlapping a driven bus or a write pulse, or an address moving under chip enable. The bench's edge monitors flag these on the same cycle. A wrong poll decision shows up as a response that arrives while the modelled memory is still busy, or more than one poll period after it finishes, and it is caught at that response. A broken watchdog gives either a hang or a timeout latency outside a window of one poll period.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_PGAP,
    ST_PRD,
    ST_RRD,
    ST_RSP
  } seq_st_t;
endpackage

// File: rtl/eep_phase_timer.sv
// Counts cycles spent in the current phase; last is high on the final one.
module eep_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == limit - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)    cnt_d = '0;
    else if (!last) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eep_poll_watchdog.sv
// Saturating cycle counter bounding the write-completion polling.
module eep_poll_watchdog #(
  parameter int LIMIT = 1250000,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q >= TW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (arm)                  cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eep_host_seq.sv
module eep_host_seq
  import eep_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int T_SETUP     = 1,
  parameter int T_WPULSE    = 14,
  parameter int T_HOLD      = 2,
  parameter int T_GAP       = 2,
  parameter int T_RDACC     = 12,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_timeout,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int M1   = (T_SETUP > T_WPULSE) ? T_SETUP : T_WPULSE;
  localparam int M2   = (T_HOLD > T_GAP) ? T_HOLD : T_GAP;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > T_RDACC) ? M3 : T_RDACC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int MSB  = DATA_W - 1;

  seq_st_t st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d, rd_q, rd_d;
  logic              to_q, to_d;
  logic [CW-1:0]     lim;
  logic              ph_last, wd_exp, take, sample, match;

  assign take   = cmd_valid && cmd_ready;
  assign sample = ph_last && (st_q == ST_PRD || st_q == ST_RRD);
  assign match  = (mem_dq_in[MSB] == wd_q[MSB]);

  always_comb begin
    case (st_q)
      ST_WSET: lim = CW'(T_SETUP);
      ST_WPUL: lim = CW'(T_WPULSE);
      ST_WHLD: lim = CW'(T_HOLD);
      ST_PGAP: lim = CW'(T_GAP);
      ST_PRD,
      ST_RRD:  lim = CW'(T_RDACC);
      default: lim = CW'(1);
    endcase
  end

  eep_phase_timer #(.CW(CW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_d != st_q),
    .limit   (lim),
    .last    (ph_last)
  );

  eep_poll_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (st_q == ST_WHLD),
    .run     (st_q == ST_PGAP || st_q == ST_PRD),
    .expired (wd_exp)
  );

  // next-state and datapath enables
  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    to_d   = to_q;
    if (take) begin
      addr_d = cmd_addr;
      wd_d   = cmd_wdata;
    end
    if (sample) begin
      rd_d = mem_dq_in;
      to_d = (st_q == ST_PRD) && !match;
    end
    case (st_q)
      ST_IDLE: if (take) st_d = cmd_wr ? ST_WSET : ST_RRD;
      ST_WSET: if (ph_last) st_d = ST_WPUL;
      ST_WPUL: if (ph_last) st_d = ST_WHLD;
      ST_WHLD: if (ph_last) st_d = ST_PGAP;
      ST_PGAP: if (ph_last) st_d = ST_PRD;
      ST_PRD:  if (ph_last) st_d = (match || wd_exp) ? ST_RSP : ST_PGAP;
      ST_RRD:  if (ph_last) st_d = ST_RSP;
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      to_q   <= to_d;
    end
  end

  // strobe decode from the registered state
  assign cmd_ready   = (st_q == ST_IDLE);
  assign rsp_valid   = (st_q == ST_RSP);
  assign rsp_data    = rd_q;
  assign rsp_timeout = to_q;
  assign mem_dq_oe   = (st_q == ST_WSET) || (st_q == ST_WPUL) || (st_q == ST_WHLD);
  assign mem_we_n    = !(st_q == ST_WPUL);
  assign mem_oe_n    = !((st_q == ST_PRD) || (st_q == ST_RRD));
  assign mem_ce_n    = !(mem_dq_oe || !mem_oe_n);
  assign mem_addr    = addr_q;
  assign mem_dq_out  = wd_q;
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
  parameter int T_WPULSE = 14,
  parameter int T_RDACC  = 12,
  parameter int ADDR_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int RW = 16;
  logic [RW-1:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? '0 : we_run + RW'(1);
      oe_run <= mem_oe_n ? '0 : oe_run + RW'(1);
    end
  end

  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_RSP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (cmd_ready && !rsp_valid)); // R2
  AST_WE_OE_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R4
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == RW'(T_WPULSE))); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr))); // R5
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RW'(T_RDACC))); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R7
endmodule

bind eep_host_seq eep_seq_chk #(
  .T_WPULSE (T_WPULSE),
  .T_RDACC  (T_RDACC),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sim_eep_host_seq.sv
`timescale 1ns/1ps
module sim_eep_host_seq;
  localparam int AW = 11, DW = 8;
  localparam int TS = 1, TP = 14, TH = 2, TG = 2, TA = 12, TO = 2000;
  localparam int PROG = 400, MACC = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_timeout;
  logic [DW-1:0] rsp_data, mem_dq_out, dev;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eep_host_seq #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_WPULSE(TP),
    .T_HOLD(TH), .T_GAP(TG), .T_RDACC(TA), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(dev));

  function automatic logic [7:0] seed(int k);
    return 8'((k * 13) ^ (k >> 3) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [0:2047];
  logic busy, we_q, stuck = 1'b0;
  int bcnt, acc, done_cyc;
  logic [AW-1:0] la;
  logic [7:0] ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2048; k++) mem[k] <= seed(k);
      busy <= 1'b0; bcnt <= 0; we_q <= 1'b1; acc <= 0; done_cyc <= 0;
      la <= '0; ld <= '0;
    end else begin
      we_q <= mem_we_n;
      acc  <= (!mem_ce_n && !mem_oe_n) ? acc + 1 : 0;
      if (!we_q && mem_we_n && !mem_ce_n) begin
        la <= mem_addr; ld <= mem_dq_out; busy <= 1'b1; bcnt <= PROG;
      end else if (busy && !stuck) begin
        if (bcnt == 1) begin busy <= 1'b0; mem[la] <= ld; done_cyc <= cyc; end
        bcnt <= bcnt - 1;
      end
    end
  end

  always_comb begin
    if (mem_ce_n || mem_oe_n)           dev = 8'hFF;
    else if (acc < MACC)                dev = 8'h96;
    else if (busy && mem_addr == la)    dev = {~ld[7], 7'h2A};
    else if (busy)                      dev = 8'h3C;
    else                                dev = mem[mem_addr];
  end

  // ---------------- edge monitors ----------------
  int we_lo = 0, oe_hi = 100;
  logic [AW-1:0] pa;
  logic pce = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) begin
      we_lo++;
      chk(mem_oe_n && !mem_ce_n && mem_dq_oe, "R4 strobe levels", {mem_oe_n, mem_ce_n, mem_dq_oe}, 3'b101);
    end else if (we_lo != 0) begin
      chk(we_lo == TP, "R4 we pulse", we_lo, TP);
      we_lo = 0;
    end
    if (!mem_oe_n && mem_dq_oe) chk(0, "R7 contention", 1, 0);
    if (!mem_oe_n && oe_hi != 0) begin
      chk(oe_hi >= TG, "R8 poll gap", oe_hi, TG);
      oe_hi = 0;
    end else if (mem_oe_n) oe_hi++;
    if (!pce && !mem_ce_n && mem_addr != pa) chk(0, "R5 addr moved", mem_addr, pa);
    pce = mem_ce_n; pa = mem_addr;
  end

  // ---------------- command driver ----------------
  task automatic run_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit intrude, output logic [DW-1:0] rd, output bit to,
                         output int lat);
    int t0, rdy_seen;
    rdy_seen = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = wr; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (intrude) begin
      for (int k = 0; k < 30; k++) begin
        cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_addr = 11'd1000; cmd_wdata = 8'h00;
        if (cmd_ready) rdy_seen++;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    while (!rsp_valid) begin
      if (cmd_ready) rdy_seen++;
      @(negedge clk);
    end
    chk(rdy_seen == 0 && !cmd_ready, "R2 ready low while busy", rdy_seen, 0);
    rd = rsp_data; to = rsp_timeout; lat = cyc - t0;
    if (wr && !stuck) begin
      chk(!busy, "R8 done while memory busy", busy, 0);
      chk(cyc - done_cyc <= TG + TA + 4, "R8 late completion", cyc - done_cyc, TG + TA + 4);
    end
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R2 ready after rsp", {cmd_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    bit to;
    int lat;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);

    // unwritten reads
    for (int i = 0; i < 5; i++) begin
      a = AW'(i * 409 + 3);
      run_cmd(1'b0, a, '0, 1'b0, rd, to, lat);
      chk(rd == seed(int'(a)) && !to, "R6 read data", rd, seed(int'(a)));
    end

    // write/readback sweep, both values of bit 7, both address ends
    for (int i = 0; i < 12; i++) begin
      a = (i == 0) ? AW'(0) : (i == 11) ? AW'(2047) : AW'(i * 171);
      d = 8'(i * 37) ^ ((i % 2) ? 8'h80 : 8'h00);
      run_cmd(1'b1, a, d, 1'b0, rd, to, lat);
      chk(!to && rd == d, "R8 write completes", {to, rd}, {1'b0, d});
      run_cmd(1'b0, a, '0, 1'b0, rd, to, lat);
      chk(rd == d, "R6 readback", rd, d);
    end

    // command offered while busy is ignored
    run_cmd(1'b1, 11'd77, 8'hC3, 1'b1, rd, to, lat);
    run_cmd(1'b0, 11'd1000, '0, 1'b0, rd, to, lat);
    chk(rd == seed(1000), "R3 busy command ignored", rd, seed(1000));

    // memory never finishes: timeout
    stuck = 1'b1;
    run_cmd(1'b1, 11'd500, 8'h11, 1'b0, rd, to, lat);
    chk(to == 1'b1, "R9 timeout flag", to, 1);
    chk(lat >= TO && lat <= TO + TS + TP + TH + 2 * (TG + TA) + 4, "R9 timeout latency",
        lat, TO);
    repeat (20) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R9 no strobe after timeout",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    stuck = 1'b0;
    repeat (PROG + 20) @(negedge clk);
    run_cmd(1'b0, 11'd500, '0, 1'b0, rd, to, lat);
    chk(rd == 8'h11 && !to, "R6 read after late finish", rd, 8'h11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule